// File: doc/BRIEF.md
# Quasi-Bidirectional GPIO Port Bank

This block provides a bank of byte-wide general-purpose I/O ports. Each pin behaves quasi-bidirectionally. A zero in the pin's output latch turns on a strong low driver. A one releases the pin to a weak pull-up, and the pin can then be used as an input. Software reaches the bank over a small parallel I/O bus that has an address, a byte of write data, a byte of read data and active-low read and write strobes.

Reads of a port address always return the levels actually present on the pins, after a multi-stage synchronizer, and never the latch contents. A per-bit polarity register chooses whether a pin is active when high or when low. When a synchronized pin enters its active level, a sticky pending bit is set. Software clears a pending bit by writing a one to it. A per-port enable register gates the pending bits onto a single interrupt request. A global input-only strap blocks all low drive without disturbing the latches.

The register layout is made of four regions, each `NUM_PORTS` entries wide, placed relative to `BASE_ADDR`. With the defaults (`BASE_ADDR`=0, four ports) the map is: port pins and latches at 0..3, polarity at 4..7, pending at 8..11 and the enable register at 12.

Top module: `qbio_port_bank`

## Requirements
- R1: After reset every output latch bit is 1, so no pin drives low and every pull-up is on. Polarity, pending and enable registers are all 0, and `irq` is 0.
- R2: Writing to address BASE_ADDR+p loads the latch of port p. A latch bit of 0 asserts the matching `pin_drive_low` bit. A latch bit of 1 deasserts it and asserts the matching `pin_pullup_en` bit. Pin bit p*8+b belongs to port p, bit b.
- R3: While `input_only` is 1, every `pin_drive_low` bit is 0 and every `pin_pullup_en` bit is 1, whatever is written. The latches keep their values, so clearing the strap restores the earlier drive pattern.
- R4: A read of address BASE_ADDR+p returns the synchronized levels of port p's pins, not its latch. With two stages, a pin change first shows on a read in the cycle after the second rising edge that follows it.
- R5: The register at BASE_ADDR+NUM_PORTS+p holds port p's polarity and can be read back. Bit value 1 makes the pin active when high, so a rise is an event. Bit value 0 makes it active when low, so a fall is an event. A change away from the active level sets nothing.
- R6: A pending bit is set on the rising edge after the synchronized pin enters its active level, which is the third rising edge after the pin change. It stays set while the pin changes further. Port p's pending byte is read at BASE_ADDR+2*NUM_PORTS+p.
- R7: Writing to a pending address clears exactly the bits written as 1. Bits written as 0 are left unchanged.
- R8: The enable register at BASE_ADDR+3*NUM_PORTS holds one bit per port in bits [NUM_PORTS-1:0]. `irq` is 1 exactly when some port has its enable bit set and at least one pending bit set.
- R9: Writes to addresses outside the four regions change no state. Reads from them return 0, and `io_rdata` is 0 whenever `io_rd_n` is 1.
- R10: A write takes effect on a rising edge at which `io_wr_n` is 0 and updates all eight bits of the addressed register together. With `io_wr_n` at 1, the address and data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O bus address |
| io_wdata | input | 8 | I/O bus write data |
| io_wr_n | input | 1 | Write strobe, active low |
| io_rd_n | input | 1 | Read strobe, active low |
| io_rdata | output | 8 | Read data, 0 when no read is active |
| input_only | input | 1 | Strap that blocks all low drive |
| pin_in | input | 32 | Sampled pin levels, port p at bits [8p+7:8p] |
| pin_drive_low | output | 32 | Strong low driver enable per pin |
| pin_pullup_en | output | 32 | Weak pull-up enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check every cycle that the strap keeps all low drive off, and that a write to port 0 shows its inverted data on the low drivers one cycle later. They also check that clearing the enable register silences `irq` and that unmapped reads return zero. Only the bench scenarios can show the synchronizer latency seen on reads, and that a move away from the active level sets nothing. The same holds for sticky pending bits that survive later pin changes, for selective write-one-to-clear, and for the per-port gating of the interrupt.

// File: rtl/qbio_pkg.sv
package qbio_pkg;

   typedef enum logic [2:0] {
      RK_NONE,
      RK_LATCH,
      RK_POL,
      RK_PEND,
      RK_EN
   } region_e;

   // Map an address offset to a register region; each region spans np entries.
   function automatic region_e classify(input logic [31:0] off, input int unsigned np);
      if (off < np)              return RK_LATCH;
      else if (off < 2 * np)     return RK_POL;
      else if (off < 3 * np)     return RK_PEND;
      else if (off == 3 * np)    return RK_EN;
      else                       return RK_NONE;
   endfunction

endpackage

// File: rtl/qbio_sync.sv
module qbio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '1;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/qbio_port_slice.sv
module qbio_port_slice #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] wdata,
   input  logic         lat_we,
   input  logic         pol_we,
   input  logic         pend_clr,
   input  logic         input_only,
   input  logic [W-1:0] pin_s,
   output logic [W-1:0] pol_o,
   output logic [W-1:0] pend_o,
   output logic [W-1:0] drive_low_o,
   output logic [W-1:0] pullup_o
);
   logic [W-1:0] latch_q;
   logic [W-1:0] pol_q;
   logic [W-1:0] pend_q;
   logic [W-1:0] prev_q;
   logic [W-1:0] enter_act;
   logic [W-1:0] clr_mask;

   // pin reached its active level this cycle
   assign enter_act = (pol_q & pin_s & ~prev_q) | (~pol_q & ~pin_s & prev_q);
   assign clr_mask  = pend_clr ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '1;
         pol_q   <= '0;
         pend_q  <= '0;
         prev_q  <= '1;
      end else begin
         if (lat_we) latch_q <= wdata;
         if (pol_we) pol_q   <= wdata;
         pend_q <= (pend_q & ~clr_mask) | enter_act;
         prev_q <= pin_s;
      end
   end

   assign drive_low_o = input_only ? '0 : ~latch_q;
   assign pullup_o    = ~drive_low_o;
   assign pol_o       = pol_q;
   assign pend_o      = pend_q;
endmodule

// File: rtl/qbio_port_bank.sv
module qbio_port_bank
   import qbio_pkg::*;
#(
   parameter int NUM_PORTS   = 4,
   parameter int PORT_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int BASE_ADDR   = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             io_addr,
   input  logic [PORT_W-1:0]             io_wdata,
   input  logic                          io_wr_n,
   input  logic                          io_rd_n,
   output logic [PORT_W-1:0]             io_rdata,
   input  logic                          input_only,
   input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
   output logic [NUM_PORTS*PORT_W-1:0]   pin_drive_low,
   output logic [NUM_PORTS*PORT_W-1:0]   pin_pullup_en,
   output logic                          irq
);
   localparam int TOTAL_PINS = NUM_PORTS * PORT_W;
   localparam int LAST_OFF   = 3 * NUM_PORTS;

   // elaboration-time parameter checks
   if (NUM_PORTS < 1 || NUM_PORTS > PORT_W) begin : g_bad_ports
      $error("NUM_PORTS must be between 1 and PORT_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (BASE_ADDR < 0 || BASE_ADDR + LAST_OFF >= (1 << ADDR_W)) begin : g_bad_map
      $error("register map does not fit the address space");
   end

   logic [TOTAL_PINS-1:0] pin_s;
   logic [31:0]           off;
   logic [31:0]           idx;
   region_e               rgn;
   logic                  wr_act;
   logic [PORT_W-1:0]     pol_v  [NUM_PORTS];
   logic [PORT_W-1:0]     pend_v [NUM_PORTS];
   logic [NUM_PORTS-1:0]  pend_any;
   logic [NUM_PORTS-1:0]  en_q;
   logic [PORT_W-1:0]     rd_val;

   qbio_sync #(.W(TOTAL_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   assign off    = 32'(io_addr) - 32'(BASE_ADDR);
   assign rgn    = classify(off, NUM_PORTS);
   assign idx    = off % 32'(NUM_PORTS);
   assign wr_act = !io_wr_n;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel;
      assign sel = (idx == 32'(p));

      qbio_port_slice #(.W(PORT_W)) u_slice (
         .clk         (clk),
         .rst_n       (rst_n),
         .wdata       (io_wdata),
         .lat_we      (wr_act && rgn == RK_LATCH && sel),
         .pol_we      (wr_act && rgn == RK_POL && sel),
         .pend_clr    (wr_act && rgn == RK_PEND && sel),
         .input_only  (input_only),
         .pin_s       (pin_s[p*PORT_W +: PORT_W]),
         .pol_o       (pol_v[p]),
         .pend_o      (pend_v[p]),
         .drive_low_o (pin_drive_low[p*PORT_W +: PORT_W]),
         .pullup_o    (pin_pullup_en[p*PORT_W +: PORT_W])
      );

      assign pend_any[p] = |pend_v[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        en_q <= '0;
      else if (wr_act && rgn == RK_EN)   en_q <= io_wdata[NUM_PORTS-1:0];
   end

   assign irq = |(pend_any & en_q);

   always_comb begin
      rd_val = '0;
      for (int q = 0; q < NUM_PORTS; q++) begin
         if (idx == 32'(q)) begin
            case (rgn)
               RK_LATCH: rd_val = pin_s[q*PORT_W +: PORT_W];
               RK_POL:   rd_val = pol_v[q];
               RK_PEND:  rd_val = pend_v[q];
               default:  ;
            endcase
         end
      end
      if (rgn == RK_EN) rd_val = PORT_W'(en_q);
   end

   assign io_rdata = io_rd_n ? '0 : rd_val;
endmodule

// File: rtl/qbio_port_bank_chk.sv
module qbio_port_bank_chk #(
   parameter int NUM_PORTS = 4,
   parameter int PORT_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 0
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [ADDR_W-1:0]           io_addr,
   input logic [PORT_W-1:0]           io_wdata,
   input logic                        io_wr_n,
   input logic                        io_rd_n,
   input logic [PORT_W-1:0]           io_rdata,
   input logic                        input_only,
   input logic [NUM_PORTS*PORT_W-1:0] pin_drive_low,
   input logic                        irq
);
   localparam logic [31:0] EN_ADDR = 32'(BASE_ADDR + 3 * NUM_PORTS);

   // R1
   reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_drive_low == '0 && !irq));

   // R3
   strap_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      input_only |-> pin_drive_low == '0);

   // R2
   port0_write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_wr_n && 32'(io_addr) == 32'(BASE_ADDR) && !input_only)
      |=> (input_only || pin_drive_low[PORT_W-1:0] == ~$past(io_wdata)));

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_wr_n && 32'(io_addr) == EN_ADDR && io_wdata[NUM_PORTS-1:0] == '0)
      |=> !irq);

   // R9
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_rd_n && 32'(io_addr) > EN_ADDR) |-> io_rdata == '0);
endmodule

bind qbio_port_bank qbio_port_bank_chk #(
   .NUM_PORTS (NUM_PORTS),
   .PORT_W    (PORT_W),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .io_addr       (io_addr),
   .io_wdata      (io_wdata),
   .io_wr_n       (io_wr_n),
   .io_rd_n       (io_rd_n),
   .io_rdata      (io_rdata),
   .input_only    (input_only),
   .pin_drive_low (pin_drive_low),
   .irq           (irq)
);

// File: tb/qbio_port_bank_bench.sv
module qbio_port_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = '0;
   logic [7:0]  io_wdata = '0;
   logic        io_wr_n = 1'b1;
   logic        io_rd_n = 1'b1;
   logic [7:0]  io_rdata;
   logic        input_only = 1'b0;
   logic [31:0] pin_in = 32'hFFFF_FFFF;
   logic [31:0] pin_drive_low;
   logic [31:0] pin_pullup_en;
   logic        irq;

   int total = 0;
   int fails = 0;
   int cyc   = 0;
   bit done  = 0;

   typedef struct {
      string      tag;
      logic [7:0] exp;
   } rd_item_t;
   rd_item_t exp_q[$];

   always #10 clk = ~clk;

   qbio_port_bank u_qbio_port_bank (
      .clk           (clk),
      .rst_n         (rst_n),
      .io_addr       (io_addr),
      .io_wdata      (io_wdata),
      .io_wr_n       (io_wr_n),
      .io_rd_n       (io_rd_n),
      .io_rdata      (io_rdata),
      .input_only    (input_only),
      .pin_in        (pin_in),
      .pin_drive_low (pin_drive_low),
      .pin_pullup_en (pin_pullup_en),
      .irq           (irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   // driver tasks start and end at a falling edge
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      io_addr = a; io_wdata = d; io_wr_n = 1'b0;
      @(negedge clk);
      io_wr_n = 1'b1;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      rd_item_t it;
      it.tag = tag; it.exp = exp;
      exp_q.push_back(it);
      io_addr = a; io_rd_n = 1'b0;
      @(negedge clk);
      io_rd_n = 1'b1;
   endtask

   // monitor: compare read data against the scoreboard mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (!io_rd_n) begin
            if (exp_q.size() == 0) begin
               total++; fails++;
               $display("FAIL scoreboard empty actual=%h expected=none", io_rdata);
            end else begin
               rd_item_t it;
               it = exp_q.pop_front();
               check(it.tag, 32'(io_rdata), 32'(it.exp));
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         total++; fails++;
         $display("FAIL watchdog actual=%0d expected<=5000", cyc);
         summary();
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      check("R1 drive_low", pin_drive_low, 32'h0);
      check("R1 pullup", pin_pullup_en, 32'hFFFF_FFFF);
      check("R1 irq", 32'(irq), 32'h0);
      rd(8'd4, 8'h00, "R1 polarity reset");
      rd(8'd9, 8'h00, "R1 pending reset");
      rd(8'd12, 8'h00, "R1 enable reset");

      // R2 / R10 write a latch byte
      wr(8'd0, 8'h5A);
      check("R2 drive_low port0", pin_drive_low, 32'h0000_00A5);
      check("R2 pullup port0", pin_pullup_en, 32'hFFFF_FF5A);
      io_addr = 8'd1; io_wdata = 8'h00;
      idle(1);
      check("R10 no strobe no change", pin_drive_low, 32'h0000_00A5);

      // R4 reads give pins, through the synchronizer
      rd(8'd0, 8'hFF, "R4 read gives pins not latch");
      pin_in[7:0] = 8'h3C;
      idle(1);
      rd(8'd0, 8'hFF, "R4 one edge after change");
      rd(8'd0, 8'h3C, "R4 two edges after change");

      // R3 input-only strap
      input_only = 1'b1;
      wr(8'd2, 8'h00);
      check("R3 strap drive_low", pin_drive_low, 32'h0);
      check("R3 strap pullup", pin_pullup_en, 32'hFFFF_FFFF);
      input_only = 1'b0;
      #1;
      check("R3 strap cleared", pin_drive_low, 32'h00FF_00A5);
      wr(8'd2, 8'hFF);

      // R9 unmapped
      wr(8'h20, 8'h00);
      check("R9 unmapped write", pin_drive_low, 32'h0000_00A5);
      rd(8'h20, 8'h00, "R9 unmapped read");
      io_addr = 8'd0;
      #1;
      check("R9 idle rdata", 32'(io_rdata), 32'h0);

      // R6 port0 active-low: FF->3C falls on bits 7,6,1,0
      rd(8'd8, 8'hC3, "R6 port0 pending on falls");

      // R5 polarity of port1 bit0 active high
      wr(8'd5, 8'h01);
      rd(8'd5, 8'h01, "R5 polarity readback");
      wr(8'd12, 8'h02);
      pin_in[15:8] = 8'hFE;
      idle(4);
      rd(8'd9, 8'h00, "R5 fall on active-high pin ignored");
      check("R8 irq idle", 32'(irq), 32'h0);
      pin_in[15:8] = 8'hFF;
      idle(2);
      rd(8'd9, 8'h00, "R6 not before third edge");
      rd(8'd9, 8'h01, "R6 rise sets pending");
      check("R8 irq with enable", 32'(irq), 32'h1);
      pin_in[15:8] = 8'hFD;
      idle(4);
      rd(8'd9, 8'h03, "R6 active-low fall sets pending");
      pin_in[15:8] = 8'hFF;
      idle(4);
      rd(8'd9, 8'h03, "R6 sticky after return");

      // R7 write-one-to-clear
      wr(8'd9, 8'h01);
      rd(8'd9, 8'h02, "R7 selective clear");
      check("R8 irq still pending", 32'(irq), 32'h1);
      wr(8'd12, 8'h00);
      check("R8 irq masked", 32'(irq), 32'h0);
      rd(8'd9, 8'h02, "R8 mask keeps pending");
      wr(8'd12, 8'h01);
      check("R8 port0 enable", 32'(irq), 32'h1);
      wr(8'd8, 8'hFF);
      check("R7 clear port0 drops irq", 32'(irq), 32'h0);
      rd(8'd8, 8'h00, "R7 port0 cleared");
      wr(8'd9, 8'h02);
      rd(8'd9, 8'h00, "R7 port1 cleared");
      rd(8'd12, 8'h01, "R8 enable readback");

      idle(2);
      check("scoreboard drained", 32'(exp_q.size()), 32'h0);
      done = 1;
      summary();
   end
endmodule